// File: doc/BRIEF.md
# Index-Register Address Generator

This block turns each instruction word of a bit-serial processor into a data-memory bit address. An instruction carries a 10-bit offset, a zero-page flag and a register-select flag. With the zero-page flag set, the offset alone is the address. With the flag clear, the offset is merged with one of two 15-bit index registers by a bitwise OR. No adder is used, so no carries form.

The lowest 32 bit addresses hold machine state, and the block serves them itself. Address 0 reads back the accumulator bit, and writing a 1 there halts the machine. Addresses 1 to 15 expose the index register that the current instruction did *not* select, most significant bit first. Addresses 16 to 31 hold the 16-bit jump-destination register, also most significant bit first. Everything from address 32 upward is flagged for the main memory array, which lies outside this block.

Writes to mapped state commit on the clock edge that ends the instruction. Only the unselected index register can be written, so a write never moves the address of the access that performs it.

Top module: `idx_addr_gen`

## Requirements
- R1: When instruction bit 11 (zero-page) is 1, `eff_addr` equals instruction bits 9:0 zero-extended to 15 bits.
- R2: When instruction bit 11 is 0, `eff_addr` equals the selected index register bitwise-ORed with instruction bits 9:0, with no carry between bit positions.
- R3: Instruction bit 10 selects index register A when 0 and index register B when 1, both for address forming and for deciding which register is unselected.
- R4: When `eff_addr` is 0, `map_rd_bit` equals `acc_bit`.
- R5: A write (`wr_en`=1) of `wr_data`=1 at address 0 sets `halt` on the next clock edge, and `halt` then stays set until reset. A write of 0 at address 0 leaves `halt` unchanged.
- R6: Addresses 1 to 15 read and write the unselected index register, with address 1 at bit 14 and address 15 at bit 0 (bit = 15 − address).
- R7: Addresses 16 to 31 read and write the jump-destination register, with address 16 at bit 15 and address 31 at bit 0 (bit = 31 − address). The whole register is presented on `jump_dest`.
- R8: For addresses 32 and above, `mem_sel` is 1 and `map_rd_bit` is 0, and writes change no mapped state. For addresses below 32, `mem_sel` is 0.
- R9: Mapped writes take effect at the clock edge only, and a write to an index register leaves the effective address of the same, unchanged instruction unchanged.
- R10: A synchronous active-low reset clears both index registers, the jump-destination register and `halt`.
- R11: While `wr_en` is 0, no mapped state changes, whatever the address and data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; mapped writes commit on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| instr | input | 16 | Current instruction word |
| wr_data | input | 1 | Bit being written by the current instruction |
| wr_en | input | 1 | Write strobe for the current instruction |
| acc_bit | input | 1 | Present accumulator value |
| eff_addr | output | 15 | Effective data bit address |
| mem_sel | output | 1 | Address lies in main memory (32 and above) |
| map_rd_bit | output | 1 | Read bit from the mapped region |
| halt | output | 1 | Sticky halt flag |
| jump_dest | output | 16 | Jump-destination register contents |

## Verification
The hardest case to reach from the ports is an indexed access whose base is an index register loaded through the map. Indexed accesses only become meaningful after both registers have been filled, bit by bit, under the opposite select bit. The stimulus first loads each index register MSB-first through zero-page writes with the other register selected. It then issues indexed reads and writes, including bases whose set bits overlap the offset, and bases small enough that the indexed address falls back into the mapped region itself. Writes to an index register are also held across several cycles with the instruction unchanged, to show that the access address does not move.

// File: rtl/iag_pkg.sv
// Package: shared sizes, region type and region classifier for the
// index-register address generator. Assumes the mapped window is the
// lowest 2*MAP_SPAN bit addresses.
package iag_pkg;

    localparam int INSTR_W = 16;
    localparam int OFS_W   = 10;
    localparam int IDX_W   = 15;
    localparam int JD_W    = 16;
    localparam int SEL_BIT = 10;
    localparam int ZP_BIT  = 11;
    localparam int POS_W   = $clog2(JD_W);
    localparam int MAP_SPAN = JD_W;

    typedef enum logic [1:0] {
        RG_ACC  = 2'd0,
        RG_IDX  = 2'd1,
        RG_JMP  = 2'd2,
        RG_MAIN = 2'd3
    } region_e;

    // Classify a bit address into one of the four regions.
    function automatic region_e classify(input logic [IDX_W-1:0] a);
        if (a == '0)
            return RG_ACC;
        else if (a < IDX_W'(MAP_SPAN))
            return RG_IDX;
        else if (a < IDX_W'(2 * MAP_SPAN))
            return RG_JMP;
        else
            return RG_MAIN;
    endfunction

endpackage

// File: rtl/iag_addr_former.sv
// Address former: combines the instruction offset with the selected index
// register by bitwise OR, or passes the offset alone in zero-page mode.
// Also hands back the unselected register for map readback.
// Assumes OFS_W <= IDX_W.
module iag_addr_former #(
    parameter int IDX_W = 15,
    parameter int OFS_W = 10
) (
    input  logic [OFS_W-1:0] ofs,
    input  logic             zp,
    input  logic             sel,
    input  logic [IDX_W-1:0] idx_a,
    input  logic [IDX_W-1:0] idx_b,
    output logic [IDX_W-1:0] addr,
    output logic [IDX_W-1:0] other
);
    localparam int PAD_W = IDX_W - OFS_W;

    logic [IDX_W-1:0] base;
    logic [IDX_W-1:0] ofs_ext;

    // Select base and the register left over for the map.
    always_comb begin
        base  = sel ? idx_b : idx_a;
        other = sel ? idx_a : idx_b;
    end

    assign ofs_ext = {{PAD_W{1'b0}}, ofs};

    // Form the address: OR-merge when indexed, offset only when zero-page.
    always_comb begin
        if (zp)
            addr = ofs_ext;
        else
            addr = base | ofs_ext;
    end
endmodule

// File: rtl/iag_map_decoder.sv
// Map decoder: classifies the effective address and yields the bit
// position inside the addressed mapped register (MSB at lowest address).
// Assumes each mapped window is 2**POS_W addresses and aligned.
module iag_map_decoder
    import iag_pkg::*;
#(
    parameter int IDX_W = 15,
    parameter int POS_W = 4
) (
    input  logic [IDX_W-1:0] addr,
    output region_e          region,
    output logic [POS_W-1:0] pos
);
    // Region of the current address.
    always_comb region = classify(addr);

    // Bit position: lowest address in a window is the top bit.
    always_comb pos = ~addr[POS_W-1:0];
endmodule

// File: rtl/iag_bit_reg.sv
// Bit-addressable register: one bit is written per cycle at position
// pos when wr is high; synchronous active-low reset clears it. Positions
// at or above W are ignored.
module iag_bit_reg #(
    parameter int W     = 16,
    parameter int POS_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr,
    input  logic [POS_W-1:0] pos,
    input  logic             d,
    output logic [W-1:0]     q
);
    // Per-bit write enables, one comparator per bit.
    logic [W-1:0] hit;

    for (genvar b = 0; b < W; b++) begin : g_bit
        assign hit[b] = wr && (pos == POS_W'(b));

        // Hold or update a single bit.
        always_ff @(posedge clk) begin
            if (!rst_n)
                q[b] <= 1'b0;
            else if (hit[b])
                q[b] <= d;
        end
    end
endmodule

// File: rtl/idx_addr_gen.sv
// Top: index-register address generator with its low memory-mapped
// window (accumulator readback, halt, unselected index register, jump
// destination). Assumes one access per clock, with writes committing at
// the rising edge. The main memory itself is outside this block.
module idx_addr_gen
    import iag_pkg::*;
#(
    parameter int IW   = INSTR_W,
    parameter int OW   = OFS_W,
    parameter int XW   = IDX_W,
    parameter int JW   = JD_W,
    parameter int NIDX = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [IW-1:0] instr,
    input  logic          wr_data,
    input  logic          wr_en,
    input  logic          acc_bit,
    output logic [XW-1:0] eff_addr,
    output logic          mem_sel,
    output logic          map_rd_bit,
    output logic          halt,
    output logic [JW-1:0] jump_dest
);
    localparam int PW = $clog2(JW);

    logic [OW-1:0] ofs;
    logic          zp;
    logic          sel;
    logic          unused_opc;
    region_e       region;
    logic [PW-1:0] pos;
    logic [XW-1:0] idx_q [NIDX];
    logic [XW-1:0] other;
    logic          wr_idx;
    logic          wr_jmp;
    logic          wr_halt;

    // Split the instruction fields.
    always_comb begin
        ofs = instr[OW-1:0];
        sel = instr[SEL_BIT];
        zp  = instr[ZP_BIT];
    end
    assign unused_opc = ^instr[IW-1:ZP_BIT+1];

    iag_addr_former #(.IDX_W(XW), .OFS_W(OW)) u_form (
        .ofs   (ofs),
        .zp    (zp),
        .sel   (sel),
        .idx_a (idx_q[0]),
        .idx_b (idx_q[1]),
        .addr  (eff_addr),
        .other (other)
    );

    iag_map_decoder #(.IDX_W(XW), .POS_W(PW)) u_dec (
        .addr   (eff_addr),
        .region (region),
        .pos    (pos)
    );

    // Route the write strobe to the addressed mapped state.
    always_comb begin
        wr_idx  = wr_en && (region == RG_IDX);
        wr_jmp  = wr_en && (region == RG_JMP);
        wr_halt = wr_en && (region == RG_ACC) && wr_data;
    end

    // Index registers: only the one not selected can take a write.
    for (genvar g = 0; g < NIDX; g++) begin : g_idx
        logic we_g;
        assign we_g = wr_idx && (sel != g[0]);
        iag_bit_reg #(.W(XW), .POS_W(PW)) u_reg (
            .clk   (clk),
            .rst_n (rst_n),
            .wr    (we_g),
            .pos   (pos),
            .d     (wr_data),
            .q     (idx_q[g])
        );
    end

    iag_bit_reg #(.W(JW), .POS_W(PW)) u_jdst (
        .clk   (clk),
        .rst_n (rst_n),
        .wr    (wr_jmp),
        .pos   (pos),
        .d     (wr_data),
        .q     (jump_dest)
    );

    // Sticky halt flag, cleared only by reset.
    always_ff @(posedge clk) begin
        if (!rst_n)
            halt <= 1'b0;
        else if (wr_halt)
            halt <= 1'b1;
    end

    // Read mux for the mapped window.
    always_comb begin
        unique case (region)
            RG_ACC:  map_rd_bit = acc_bit;
            RG_IDX:  map_rd_bit = (32'(pos) < XW) ? other[pos[$clog2(XW)-1:0]] : 1'b0;
            RG_JMP:  map_rd_bit = jump_dest[pos];
            default: map_rd_bit = 1'b0;
        endcase
        mem_sel = (region == RG_MAIN);
    end
endmodule

// File: rtl/iag_checker.sv
// Checker for idx_addr_gen: temporal properties over its ports.
module iag_checker #(
    parameter int XW = 15,
    parameter int JW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic [15:0]   instr,
    input logic          wr_data,
    input logic          wr_en,
    input logic [XW-1:0] eff_addr,
    input logic          mem_sel,
    input logic          map_rd_bit,
    input logic          halt,
    input logic [JW-1:0] jump_dest
);
    logic past_ok;

    // Marks cycles whose previous sample lies after reset.
    always_ff @(posedge clk) past_ok <= rst_n;

    // R1
    zp_upper_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        instr[11] |-> (eff_addr[XW-1:10] == '0));

    // R5
    halt_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n || !past_ok)
        $past(halt) |-> halt);

    // R5
    halt_cause_chk: assert property (@(posedge clk) disable iff (!rst_n || !past_ok)
        $rose(halt) |-> $past(wr_en && wr_data && eff_addr == '0));

    // R7
    jd_one_bit_chk: assert property (@(posedge clk) disable iff (!rst_n || !past_ok)
        $countones(jump_dest ^ $past(jump_dest)) <= 1);

    // R11
    jd_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n || !past_ok)
        !$past(wr_en) |-> $stable(jump_dest));

    // R8
    main_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_sel |-> !map_rd_bit);

    // R9
    idx_write_addr_chk: assert property (@(posedge clk) disable iff (!rst_n || !past_ok)
        ($past(wr_en) && $past(eff_addr) > 0 && $past(eff_addr) < 16 && $stable(instr))
        |-> $stable(eff_addr));
endmodule

bind idx_addr_gen iag_checker #(.XW(XW), .JW(JW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .instr      (instr),
    .wr_data    (wr_data),
    .wr_en      (wr_en),
    .eff_addr   (eff_addr),
    .mem_sel    (mem_sel),
    .map_rd_bit (map_rd_bit),
    .halt       (halt),
    .jump_dest  (jump_dest)
);

// File: tb/tb_idx_addr_gen.sv
`timescale 1ns/1ps
// Bench: behavioural reference model, compared after every input change.
module tb_idx_addr_gen;
    logic        clk = 0;
    logic        rst_n = 0;
    logic [15:0] instr = '0;
    logic        wr_data = 0, wr_en = 0, acc_bit = 0;
    logic [14:0] eff_addr;
    logic        mem_sel, map_rd_bit, halt;
    logic [15:0] jump_dest;

    int n_chk = 0, n_bad = 0;
    int m_idx [2];
    int m_jd;
    int m_halt;
    int seed = 12345;

    always #2.5 clk = ~clk;

    idx_addr_gen dut (.*);

    task automatic chk(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int ref_addr(int ofs, int zp, int sel);
        return zp ? ofs : (m_idx[sel] | ofs);
    endfunction

    // One instruction: drive, compare outputs, clock, update model.
    task automatic step(int ofs, int zp, int sel, int wd, int we, int acc);
        int a, rd;
        string rt;
        instr   = 16'((zp << 11) | (sel << 10) | ofs | 16'h9000);
        wr_data = wd[0]; wr_en = we[0]; acc_bit = acc[0];
        #1;
        a = ref_addr(ofs, zp, sel);
        if (a == 0) begin rd = acc; rt = "R4"; end
        else if (a < 16) begin rd = (m_idx[1-sel] >> (15 - a)) & 1; rt = "R6"; end
        else if (a < 32) begin rd = (m_jd >> (31 - a)) & 1; rt = "R7"; end
        else begin rd = 0; rt = "R8"; end
        chk(zp ? "R1" : "R2", int'(eff_addr), a);
        chk(rt, int'(map_rd_bit), rd);
        chk("R8", int'(mem_sel), a >= 32);
        chk("R5", int'(halt), m_halt);
        chk("R7", int'(jump_dest), m_jd);
        @(posedge clk);
        if (we) begin
            if (a == 0 && wd) m_halt = 1;
            else if (a > 0 && a < 16)
                m_idx[1-sel] = (m_idx[1-sel] & ~(1 << (15 - a))) | (wd << (15 - a));
            else if (a >= 16 && a < 32)
                m_jd = (m_jd & ~(1 << (31 - a))) | (wd << (31 - a));
        end
        @(negedge clk);
    endtask

    // Load a whole index register MSB-first through the map (R3, R6).
    task automatic load_idx(int which, int val);
        for (int k = 1; k < 16; k++)
            step(k, 1, 1 - which, (val >> (15 - k)) & 1, 1, 0);
    endtask

    function automatic int rnd();
        seed = seed * 1103515245 + 12345;
        return (seed >>> 8) & 32'h7fffff;
    endfunction

    initial begin
        #100000;
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=running expected=done");
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        m_idx[0] = 0; m_idx[1] = 0; m_jd = 0; m_halt = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        // R10: reset state
        step(0, 0, 0, 0, 0, 0);
        step(0, 0, 1, 0, 0, 1);
        // R4: accumulator readback at address 0 both values
        step(0, 1, 0, 0, 0, 1);
        step(0, 1, 1, 0, 0, 0);
        // R5: write of 0 at address 0 does not halt
        step(0, 1, 0, 0, 1, 1);
        // R3/R6: fill A via select 1, B via select 0
        load_idx(0, 15'h5A3C);
        load_idx(1, 15'h0013);
        // R2: OR with overlapping bits, no carry
        step(10'h3FF, 0, 0, 0, 0, 0);
        step(10'h00C, 0, 0, 0, 0, 0);
        step(10'h00F, 0, 1, 0, 0, 0);
        // R2 indexed into mapped region: B=0x13 -> jump window
        step(10'h00C, 0, 1, 1, 1, 0);
        step(10'h000, 0, 1, 1, 1, 0);
        // R7: write jump destination MSB-first
        for (int k = 16; k < 32; k++) step(k, 1, k & 1, (16'hC3A5 >> (31 - k)) & 1, 1, 0);
        // R11: writes blocked while strobe low
        for (int k = 0; k < 40; k++) step(k, 1, k & 1, 1, 0, 1);
        // R9: hold an index write instruction across cycles
        step(3, 1, 0, 0, 1, 0);
        step(3, 1, 0, 1, 1, 0);
        step(3, 1, 0, 0, 1, 0);
        step(10'h005, 0, 0, 0, 0, 0);
        // R8: main memory region, writes there change nothing
        step(10'h3A0, 1, 0, 1, 1, 0);
        step(10'h020, 1, 1, 1, 1, 0);
        step(10'h200, 0, 0, 1, 1, 0);
        // Pseudo-random mix of everything
        for (int k = 0; k < 400; k++) begin
            int r;
            r = rnd();
            step((r & 1) ? (r >> 4) & 31 : (r >> 4) & 10'h3FF, (r >> 1) & 1, (r >> 2) & 1,
                 (r >> 15) & 1, ((r >> 16) & 3) != 0 && ((r >> 4) & 31) != 0, (r >> 18) & 1);
        end
        // R5: halt set by writing 1 at address 0, then sticky
        step(0, 1, 0, 1, 1, 0);
        step(0, 1, 0, 0, 1, 0);
        step(40, 1, 0, 0, 0, 0);
        // R10: reset clears all state
        rst_n = 0;
        @(posedge clk); @(negedge clk);
        rst_n = 1;
        m_idx[0] = 0; m_idx[1] = 0; m_jd = 0; m_halt = 0;
        step(10'h011, 1, 0, 0, 0, 0);
        step(10'h001, 1, 1, 0, 0, 0);
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule